// File: doc/BRIEF.md
# Multiplier-Free Quadratic Threshold Search

This unit finds the largest unsigned integer D for which the product Y·D·D stays at or below a threshold K. A one-cycle start strobe captures the coefficient Y, the threshold K and a precision mode. The unit then scans candidate values of D upward and raises a one-cycle completion pulse when the answer is ready in the result register.

No multiplier is used. Two running accumulators hold the product term Y·D² and its next increment. Each step therefore takes two additions and one comparison. In the full-precision mode D moves by one per cycle and may take up to 65,536 steps. The coarse mode moves D by 64 per step, with the increments scaled to match. That gives a result with its six low bits cleared in about one sixty-fourth of the time.

Top module: `qts_search`

## Requirements
- R1: While reset is high and on the cycle after it, `done` is 0 and `root` is 0. A reset in the middle of a search abandons it, and no completion pulse follows.
- R2: With `coarse`=0, the result is the largest D in 0..65535 for which `coef`·D² ≤ `thresh`.
- R3: With `coarse`=1, the result is the largest multiple of 64 in 0..65472 for which `coef`·D² ≤ `thresh`. Bits [5:0] of `root` are always zero in this mode.
- R4: Let N be the number of steps: the result in full mode, or the result divided by 64 in coarse mode. `done` is high after the (N+1)-th rising edge that follows the edge on which `start` was sampled.
- R5: `done` is high for exactly one cycle. After it, `root` keeps the result until the next accepted start.
- R6: A `start` sampled while a search is running has no effect. Changes on `coef`, `thresh` or `coarse` after the accepted start have no effect on the result or the latency.
- R7: A zero coefficient makes the result reach the mode's limit: 65535 in full mode, 65472 in coarse mode. A threshold smaller than the coefficient gives 0.
- R8: With `coef`=65535 and `thresh`=2^48−1 in full mode the result is 65535. The accumulated product does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle strobe that captures the operands when idle |
| coarse | input | 1 | 1 selects the 64-step reduced-precision scan |
| coef | input | 16 | Unsigned coefficient Y |
| thresh | input | 48 | Unsigned threshold K |
| root | output | 16 | Result D; holds the last answer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse is due exactly N+1 rising edges after the edge that sampled the start strobe. N is the result in full mode and the result over 64 in coarse mode. The bench computes this expected count from the expected result in each vector. It counts edges from the start strobe, sampling on falling edges, and compares the edge on which `done` is first seen with that count. The result and the pulse width are checked on the same falling edge, and again one cycle later to confirm the result holds and the pulse has dropped.

// File: rtl/qts_pkg.sv
package qts_pkg;

    localparam int unsigned QTS_COEF_W      = 16;
    localparam int unsigned QTS_ROOT_W      = 16;
    localparam int unsigned QTS_COARSE_LOG2 = 6;

    typedef enum logic {
        QTS_IDLE = 1'b0,
        QTS_RUN  = 1'b1
    } qts_state_e;

    // log2 of the candidate stride for the selected precision
    function automatic int unsigned qts_step_log2(input logic coarse, input int unsigned lg);
        return coarse ? lg : 0;
    endfunction

endpackage

// File: rtl/qts_ctrl.sv
module qts_ctrl
    import qts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    output logic load,
    output logic advance,
    output logic busy,
    output logic done
);

    qts_state_e state_q;

    assign busy    = (state_q == QTS_RUN);
    assign load    = (state_q == QTS_IDLE) && start;
    assign advance = busy && !stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= QTS_IDLE;
            done    <= 1'b0;
        end else begin
            done <= busy && stop;
            case (state_q)
                QTS_IDLE: if (start) state_q <= QTS_RUN;
                QTS_RUN:  if (stop)  state_q <= QTS_IDLE;
                default:  state_q <= QTS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/qts_datapath.sv
module qts_datapath
    import qts_pkg::*;
#(
    parameter int unsigned COEF_W      = QTS_COEF_W,
    parameter int unsigned ROOT_W      = QTS_ROOT_W,
    parameter int unsigned COARSE_LOG2 = QTS_COARSE_LOG2,
    localparam int unsigned ACC_W      = COEF_W + 2 * ROOT_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic              coarse_in,
    input  logic [COEF_W-1:0] coef,
    input  logic [ACC_W-1:0]  thresh,
    output logic [ROOT_W-1:0] root,
    output logic              stop,
    output logic [ACC_W-1:0]  prod_o,
    output logic [ACC_W-1:0]  k_o,
    output logic              coarse_o
);

    localparam logic [ROOT_W-1:0] FULL_MAX   = '1;
    localparam logic [ROOT_W-1:0] COARSE_MAX = (FULL_MAX >> COARSE_LOG2) << COARSE_LOG2;

    typedef struct packed {
        logic [ROOT_W-1:0] d;      // current candidate
        logic [ACC_W-1:0]  prod;   // coef * d^2
        logic [ACC_W-1:0]  incr;   // amount that moves prod to the next candidate
        logic [ACC_W-1:0]  slope;  // growth of incr per step
        logic [ACC_W-1:0]  k;      // captured threshold
        logic              coarse; // captured mode
    } dp_t;

    dp_t q, init;

    int unsigned       ld_sh, run_sh;
    logic [ACC_W:0]    trial;
    logic [ROOT_W-1:0] limit, stride;

    always_comb begin
        ld_sh       = qts_step_log2(coarse_in, COARSE_LOG2);
        init.d      = '0;
        init.prod   = '0;
        init.incr   = ACC_W'(coef) << (2 * ld_sh);
        init.slope  = ACC_W'(coef) << (2 * ld_sh + 1);
        init.k      = thresh;
        init.coarse = coarse_in;
    end

    always_comb begin
        run_sh = qts_step_log2(q.coarse, COARSE_LOG2);
        stride = ROOT_W'(1) << run_sh;
        limit  = q.coarse ? COARSE_MAX : FULL_MAX;
        trial  = {1'b0, q.prod} + {1'b0, q.incr};
        stop   = (trial > {1'b0, q.k}) || (q.d == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= init;
        end else if (advance) begin
            q.d    <= q.d + stride;
            q.prod <= trial[ACC_W-1:0];
            q.incr <= q.incr + q.slope;
        end
    end

    assign root     = q.d;
    assign prod_o   = q.prod;
    assign k_o      = q.k;
    assign coarse_o = q.coarse;

endmodule

// File: rtl/qts_search.sv
module qts_search
    import qts_pkg::*;
#(
    parameter int unsigned COEF_W      = QTS_COEF_W,
    parameter int unsigned ROOT_W      = QTS_ROOT_W,
    parameter int unsigned COARSE_LOG2 = QTS_COARSE_LOG2,
    localparam int unsigned ACC_W      = COEF_W + 2 * ROOT_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              coarse,
    input  logic [COEF_W-1:0] coef,
    input  logic [ACC_W-1:0]  thresh,
    output logic [ROOT_W-1:0] root,
    output logic              done
);

    logic             load, advance, stop, busy;
    logic [ACC_W-1:0] prod_q, k_q;
    logic             coarse_q;

    qts_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .stop    (stop),
        .load    (load),
        .advance (advance),
        .busy    (busy),
        .done    (done)
    );

    qts_datapath #(
        .COEF_W      (COEF_W),
        .ROOT_W      (ROOT_W),
        .COARSE_LOG2 (COARSE_LOG2)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .advance   (advance),
        .coarse_in (coarse),
        .coef      (coef),
        .thresh    (thresh),
        .root      (root),
        .stop      (stop),
        .prod_o    (prod_q),
        .k_o       (k_q),
        .coarse_o  (coarse_q)
    );

endmodule

// File: rtl/qts_search_chk.sv
module qts_search_chk #(
    parameter int unsigned ROOT_W      = 16,
    parameter int unsigned ACC_W       = 48,
    parameter int unsigned COARSE_LOG2 = 6
)(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              busy,
    input logic [ROOT_W-1:0] root,
    input logic [ACC_W-1:0]  prod_q,
    input logic [ACC_W-1:0]  k_q,
    input logic              coarse_q
);

    // R2: the product of the reported result never exceeds the threshold
    assert_within_bound_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (prod_q <= k_q));

    // R2: the candidate never moves backwards during a scan
    assert_monotonic_R2: assert property (@(posedge clk) disable iff (rst)
        busy |=> (root >= $past(root)));

    // R3: coarse results have their low bits cleared
    assert_coarse_low_R3: assert property (@(posedge clk) disable iff (rst)
        (done && coarse_q) |-> (root[COARSE_LOG2-1:0] == '0));

    // R4: every scan begins from zero
    assert_scan_origin_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (root == '0 && prod_q == '0));

    // R5: completion pulse lasts one cycle and is never seen while running
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R5: result holds after completion unless a new start arrives
    assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(root));

    // R6: a start during a scan leaves the captured operands alone
    assert_ignore_start_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(k_q) && $stable(coarse_q)));

endmodule

bind qts_search qts_search_chk #(
    .ROOT_W      (ROOT_W),
    .ACC_W       (ACC_W),
    .COARSE_LOG2 (COARSE_LOG2)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .done     (done),
    .busy     (busy),
    .root     (root),
    .prod_q   (prod_q),
    .k_q      (k_q),
    .coarse_q (coarse_q)
);

// File: tb/qts_search_tb.sv
module qts_search_tb;

    typedef struct packed {
        logic        coarse;
        logic [15:0] y;
        logic [47:0] k;
        logic [15:0] d;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 16'd1,     48'd100,            16'd10},    // R2 exact square
        '{1'b0, 16'd1,     48'd99,             16'd9},     // R2 just below
        '{1'b0, 16'd3,     48'd1000,           16'd18},    // R2
        '{1'b0, 16'd7,     48'd0,              16'd0},     // R7 K below Y
        '{1'b0, 16'd2,     48'd1,              16'd0},     // R7 K below Y
        '{1'b0, 16'd1,     48'd1,              16'd1},     // R2
        '{1'b0, 16'd100,   48'd1000000,        16'd100},   // R2
        '{1'b1, 16'd1,     48'd100,            16'd0},     // R3
        '{1'b1, 16'd1,     48'd4096,           16'd64},    // R3 exact
        '{1'b1, 16'd1,     48'd4095,           16'd0},     // R3 just below
        '{1'b1, 16'd5,     48'd10000000,       16'd1408},  // R3
        '{1'b0, 16'd65535, 48'd16383750000,    16'd500},   // R2 wide coef
        '{1'b1, 16'd0,     48'd0,              16'd65472}, // R7 coarse cap
        '{1'b0, 16'd65535, 48'hFFFF_FFFF_FFFF, 16'd65535}  // R8 full range
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        coarse = 1'b0;
    logic [15:0] coef = '0;
    logic [47:0] thresh = '0;
    logic [15:0] root;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    qts_search u_dut (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .coarse (coarse),
        .coef   (coef),
        .thresh (thresh),
        .root   (root),
        .done   (done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // launch a search and count edges until done; returns edge count
    task automatic launch(input logic c, input logic [15:0] y, input logic [47:0] k, output int lat);
        @(negedge clk);
        coarse = c; coef = y; thresh = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        coef = ~y; thresh = ~k; coarse = ~c;   // R6: later input changes must not matter
        lat = 0;
        while (!done && lat < 70000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_vec(input vec_t v);
        int lat, exp_lat;
        exp_lat = v.coarse ? (int'(v.d) / 64 + 1) : (int'(v.d) + 1);
        launch(v.coarse, v.y, v.k, lat);
        check(done == 1'b1, "R4 done seen", longint'(done), 1);
        check(root == v.d, v.coarse ? "R3 result" : "R2 result", longint'(root), longint'(v.d));
        check(lat == exp_lat, "R4 latency", longint'(lat), longint'(exp_lat));
        if (v.coarse)
            check(root[5:0] == 6'd0, "R3 low bits", longint'(root[5:0]), 0);
        @(negedge clk);
        check(done == 1'b0, "R5 single pulse", longint'(done), 0);
        check(root == v.d, "R5 hold", longint'(root), longint'(v.d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        report();
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", longint'(done), 0);
        check(root == 16'd0, "R1 root in reset", longint'(root), 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && root == 16'd0, "R1 after reset", longint'(root), 0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R6: start pulse mid-run is ignored
        @(negedge clk);
        coarse = 1'b0; coef = 16'd1; thresh = 48'd10000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 70000) begin
            @(negedge clk);
            lat++;
            if (lat == 20) begin
                coarse = 1'b1; coef = 16'd9; thresh = 48'd4; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check(root == 16'd100, "R6 result unchanged", longint'(root), 100);
        check(lat == 101, "R6 latency unchanged", longint'(lat), 101);
        @(negedge clk);

        // R1: reset in the middle of a scan
        coarse = 1'b0; coef = 16'd1; thresh = 48'd1000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        check(root != 16'd0, "R1 scan in progress", longint'(root), 30);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(root == 16'd0 && done == 1'b0, "R1 mid-run reset", longint'(root), 0);
        lat = 0;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (done) lat++;
        end
        check(lat == 0, "R1 no pulse after reset", longint'(lat), 0);
        check(root == 16'd0, "R1 root stays clear", longint'(root), 0);

        // scan still works after reset
        run_vec('{1'b0, 16'd4, 48'd400, 16'd10});

        report();
    end

endmodule